// File: doc/BRIEF.md
# Register New-Data Flag Tracker

This block sits beside the serial engine of a bus target that exposes a small bank of byte-wide registers. Every byte that a bus controller writes into register n is stored in the bank and marks register n as holding fresh data. A local host then works through those marks one request at a time. It can take the highest-numbered pending register and clear its mark. It can read one register only if that register is marked, which also clears the mark. It can read a register without touching its mark. It can also wipe the whole bank and every mark at once.

Each host request is answered one clock later with a single-cycle response strobe and a 9-bit result. Bit 8 set (value 0x1FF) means "nothing there", and this value cannot be confused with any byte or index. A level output tells the host whether any mark is outstanding. If a bus write and a host clear hit the same register in the same cycle, the write takes priority, so fresh data is never silently dropped.

Top module: `flag_tracker`

## Requirements
- R1: A write strobe with index n and byte d stores d in register n and sets the mark of register n.
- R2: Request code 0 (take-highest) answers with the index of the highest marked register, zero-extended to 9 bits, and clears only that mark.
- R3: Request code 0 with no mark set answers 0x1FF and changes nothing.
- R4: Request code 1 (conditional read) on a marked register answers {1'b0, register byte} and clears that mark.
- R5: Request code 1 on an unmarked register answers 0x1FF and leaves all marks unchanged.
- R6: Request code 2 (wipe) clears every mark and sets every register to zero; its answer is 0x1FF.
- R7: Every request clock is followed by exactly one response strobe on the next clock, and the strobe is low in a cycle that follows no request; the result holds its value between responses.
- R8: When a write and a clearing request (code 0, 1 or 2) address the same register in one cycle, the register takes the written byte and its mark stays set; the answer reflects the state before that clock.
- R9: The pending output is high exactly when at least one mark is set.
- R10: After reset no mark is set, every register reads zero, and the response strobe is low.
- R11: Request code 3 (plain read) answers {1'b0, register byte} whatever the mark, and leaves all marks unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Bus-side byte write strobe |
| wr_idx | input | 5 | Register index of the bus write |
| wr_data | input | 8 | Byte written by the bus |
| req_valid | input | 1 | Host request strobe |
| req_op | input | 2 | Request code: 0 take-highest, 1 conditional read, 2 wipe, 3 plain read |
| req_idx | input | 5 | Register index for codes 1 and 3 |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_data | output | 9 | Result; 0x1FF means none |
| pending_any | output | 1 | High while any mark is set |

## Verification
The bus write and a host request that clears marks can land on the same clock, and the collision cases are the ones that decide whether data is lost. The bench drives a write into the very register that a take-highest, conditional read or wipe is removing in that cycle. It then judges three things: the response carries the pre-clock state, a later plain read shows the new byte, and a later take-highest still reports the register as pending. Sweeps over all 32 registers and over several mark patterns check the ordering and the none result against a bench-side model.

// File: rtl/flag_tracker_pkg.sv
package flag_tracker_pkg;
  typedef enum logic [1:0] {
    OP_TAKE_HI = 2'd0,
    OP_COND_RD = 2'd1,
    OP_WIPE    = 2'd2,
    OP_PEEK    = 2'd3
  } host_op_e;
endpackage

// File: rtl/flag_vector.sv
module flag_vector #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q, flags_d;

  // set is applied after clear so a same-cycle write always survives
  always_comb begin
    flags_d = (flags_q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/prio_enc.sv
module prio_enc #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int N     = 32,
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             clr_all,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic [N*DW-1:0] bank_flat;

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic          hit;
    logic          en;
    logic [DW-1:0] q, d;

    assign hit = wr_en && (wr_idx == IDX_W'(g));
    assign en  = hit || clr_all;

    always_comb begin
      d = hit ? wr_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign bank_flat[g*DW +: DW] = q;
  end

  assign rd_data = bank_flat[rd_idx*DW +: DW];
endmodule

// File: rtl/flag_tracker.sv
module flag_tracker #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int RSP_W    = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [IDX_W-1:0]  req_idx,
  output logic              rsp_valid,
  output logic [RSP_W-1:0]  rsp_data,
  output logic              pending_any
);
  import flag_tracker_pkg::*;

  localparam logic [RSP_W-1:0] RSP_NONE = '1;

  host_op_e              op;
  logic [NUM_REGS-1:0]   flags, set_mask, clr_mask;
  logic                  hi_any;
  logic [IDX_W-1:0]      hi_idx;
  logic [DATA_W-1:0]     rd_byte;
  logic                  wipe;
  logic [RSP_W-1:0]      rsp_d, rsp_q;
  logic                  rsp_v_q;

  assign op   = host_op_e'(req_op);
  assign wipe = req_valid && (op == OP_WIPE);

  prio_enc #(.N(NUM_REGS), .IDX_W(IDX_W)) u_enc (
    .vec (flags),
    .any (hi_any),
    .idx (hi_idx)
  );

  reg_bank #(.N(NUM_REGS), .DW(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_stb),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .clr_all (wipe),
    .rd_idx  (req_idx),
    .rd_data (rd_byte)
  );

  flag_vector #(.N(NUM_REGS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .flags    (flags)
  );

  always_comb begin
    set_mask = '0;
    if (wr_stb) set_mask = NUM_REGS'(1) << wr_idx;
  end

  // host-side clear and response selection
  always_comb begin
    clr_mask = '0;
    rsp_d    = RSP_NONE;
    if (req_valid) begin
      unique case (op)
        OP_TAKE_HI: if (hi_any) begin
          clr_mask = NUM_REGS'(1) << hi_idx;
          rsp_d    = RSP_W'(hi_idx);
        end
        OP_COND_RD: if (flags[req_idx]) begin
          clr_mask = NUM_REGS'(1) << req_idx;
          rsp_d    = {1'b0, rd_byte};
        end
        OP_WIPE: clr_mask = '1;
        OP_PEEK: rsp_d    = {1'b0, rd_byte};
        default: rsp_d    = RSP_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_q   <= RSP_NONE;
    end else begin
      rsp_v_q <= req_valid;
      if (req_valid) rsp_q <= rsp_d;
    end
  end

  assign rsp_valid   = rsp_v_q;
  assign rsp_data    = rsp_q;
  assign pending_any = |flags;
endmodule

// File: rtl/flag_tracker_chk.sv
module flag_tracker_chk #(
  parameter int RSP_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic             rsp_valid,
  input logic [RSP_W-1:0] rsp_data,
  input logic             pending_any
);
  // R7
  req_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R7
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_data));

  // R8
  write_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> pending_any);

  // R3
  take_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && !pending_any) |=> (rsp_data == '1));

  // R2
  take_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && pending_any) |=> (rsp_data[RSP_W-1] == 1'b0));

  // R6
  wipe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2 && !wr_stb) |=> !pending_any);

  // R6
  wipe_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2) |=> (rsp_data == '1));
endmodule

bind flag_tracker flag_tracker_chk #(.RSP_W(RSP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_stb      (wr_stb),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .pending_any (pending_any)
);

// File: tb/flag_tracker_test.sv
module flag_tracker_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_stb;
  logic [4:0] wr_idx;
  logic [7:0] wr_data;
  logic       req_valid;
  logic [1:0] req_op;
  logic [4:0] req_idx;
  logic       rsp_valid;
  logic [8:0] rsp_data;
  logic       pending_any;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] mflags;
  logic [7:0]  mregs [32];

  always #10 clk = ~clk;

  flag_tracker uut (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pending_any(pending_any)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int model_hi();
    int h = -1;
    for (int i = 0; i < 32; i++) if (mflags[i]) h = i;
    return h;
  endfunction

  // one clock: optional write, optional request; checks response and pending
  task automatic cyc(input bit wv, input int wi, input int wd,
                     input bit rv, input int op, input int ri);
    logic [8:0]  exp;
    logic [31:0] clr;
    string       tag;
    int          h;
    @(negedge clk);
    wr_stb = wv; wr_idx = 5'(wi); wr_data = 8'(wd);
    req_valid = rv; req_op = 2'(op); req_idx = 5'(ri);
    exp = 9'h1FF; clr = '0; tag = "R7";
    if (rv) begin
      case (op)
        0: begin
          h = model_hi();
          if (h >= 0) begin exp = 9'(h); clr[h] = 1'b1; tag = "R2"; end
          else tag = "R3";
        end
        1: if (mflags[ri]) begin exp = {1'b0, mregs[ri]}; clr[ri] = 1'b1; tag = "R4"; end
           else tag = "R5";
        2: begin clr = '1; tag = "R6"; end
        default: begin exp = {1'b0, mregs[ri]}; tag = "R11"; end
      endcase
      if (wv && clr[wi]) tag = "R8";
    end
    mflags = mflags & ~clr;
    if (rv && op == 2) for (int i = 0; i < 32; i++) mregs[i] = 8'h00;
    if (wv) begin mflags[wi] = 1'b1; mregs[wi] = 8'(wd); end
    @(posedge clk);
    #5;
    chk(rsp_valid == rv, "R7", int'(rsp_valid), int'(rv));
    if (rv) chk(rsp_data == exp, tag, int'(rsp_data), int'(exp));
    chk(pending_any == (mflags != 0), "R9", int'(pending_any), int'(mflags != 0));
  endtask

  task automatic wr(input int i, input int d);  cyc(1, i, d, 0, 0, 0); endtask
  task automatic rq(input int op, input int i); cyc(0, 0, 0, 1, op, i); endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_stb = 0; wr_idx = 0; wr_data = 0;
    req_valid = 0; req_op = 0; req_idx = 0;
    mflags = '0;
    for (int i = 0; i < 32; i++) mregs[i] = 8'h00;
    repeat (3) @(posedge clk);
    #5;
    // R10 reset state
    chk(rsp_valid == 1'b0, "R10", int'(rsp_valid), 0);
    chk(pending_any == 1'b0, "R10", int'(pending_any), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 32; i++) rq(3, i);   // R10 registers zero via plain read
    rq(0, 0);                                // R3 nothing pending

    // R1 fill every register, R11 peek all, R2 drain highest first
    for (int i = 0; i < 32; i++) wr(i, (i * 37 + 5) & 255);
    for (int i = 0; i < 32; i++) rq(3, i);
    for (int i = 0; i < 33; i++) rq(0, 0);

    // R2 several mark patterns, written in scrambled order
    for (int p = 0; p < 6; p++) begin
      logic [31:0] pat;
      pat = 32'h8800_0088 ^ (32'h1357_9BDF * (p + 1));
      for (int k = 0; k < 32; k++) begin
        int j;
        j = (k * 13 + p) & 31;
        if (pat[j]) wr(j, j ^ (p * 17));
      end
      for (int i = 0; i < 33; i++) rq(0, 0);
    end

    // R4 / R5 conditional reads over every register
    for (int i = 0; i < 32; i += 3) wr(i, 255 - i);
    for (int i = 0; i < 32; i++) rq(1, i);
    for (int i = 0; i < 32; i++) rq(1, i);

    // R6 wipe then confirm registers and marks are gone
    for (int i = 0; i < 32; i++) wr(i, i + 100);
    rq(2, 0);
    for (int i = 0; i < 32; i++) rq(3, i);
    rq(0, 0);

    // R8 collisions between write and clearing requests
    wr(3, 8'h11); wr(9, 8'h22);
    cyc(1, 9, 8'h99, 1, 0, 0);   // take-highest pops 9 while 9 rewritten
    rq(3, 9);
    rq(0, 0); rq(0, 0); rq(0, 0);
    wr(4, 8'h44);
    cyc(1, 4, 8'h55, 1, 1, 4);   // conditional read of 4 while rewritten
    rq(3, 4);
    rq(1, 4); rq(1, 4);
    wr(20, 8'h20);
    cyc(1, 6, 8'h66, 1, 2, 0);   // wipe while 6 written
    rq(3, 6); rq(3, 20);
    rq(0, 0); rq(0, 0);
    cyc(1, 7, 8'h77, 1, 1, 8);   // different register: no collision
    rq(1, 7);

    // R7 idle cycles after a response
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule